// File: doc/BRIEF.md
# Duplicated Dual-Read Register File

This block is the general-purpose register store of a scalar integer pipeline. It holds every architectural register twice, in two independent copies, as a guard against single-event upsets. Each copy has its own write-select decoder and its own read multiplexer. Each operand port is wired to one copy only. The first operand comes from copy A and the second operand comes from copy B. As a result, a corrupted bit in one copy appears on one operand and never on both.

A write-back is a plain write-enable strobe with an index and a data word. It lands in both copies on the same rising edge, so the copies stay identical. The read paths are combinational. The pipeline drives two indices and uses the two words in the same cycle. Bypassing a value that is being written in the same cycle is left to the pipeline.

The block also has a compare output. It goes high when both ports address the same register but return different words. This shows that the copies have drifted apart. Register 0 is hard-wired to zero in both copies.

Top module: `rf_dup`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, and after it is released, every register reads zero on both ports until it is written.
- R2: A write with `wr_en` high and `wr_idx` not 0 stores `wr_data` in both copies at that index on the same rising edge. From the next cycle, both ports return that word at that index.
- R3: `rd_a_data` is a combinational function of `rd_a_idx` and of copy A. A change of the index alone changes the output in the same cycle.
- R4: `rd_b_data` is a combinational function of `rd_b_idx` and of copy B. A change of the index alone changes the output in the same cycle.
- R5: Index 0 reads as zero on both ports. A write to index 0 changes nothing in either copy.
- R6: If a register is read in the same cycle that it is written, the port returns the old word before the edge and the new word after it.
- R7: `copy_mismatch` is 1 only when `rd_a_idx` equals `rd_b_idx` and the two read words differ. Otherwise it is 0. On copies that agree, it stays 0.
- R8: With `wr_en` low, no register in either copy changes, whatever `wr_idx` and `wr_data` carry.
- R9: Each entry holds its own word. Writing the alternating patterns 0x55555555 and 0xAAAAAAAA across the lower half (indices 1 to 15) and the upper half (indices 16 to 31), then the inverse patterns, reads back unchanged at every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears both copies |
| rd_a_idx | input | 5 | First operand register index |
| rd_a_data | output | 32 | First operand word, taken from copy A |
| rd_b_idx | input | 5 | Second operand register index |
| rd_b_data | output | 32 | Second operand word, taken from copy B |
| wr_en | input | 1 | Write-back strobe |
| wr_idx | input | 5 | Write-back register index |
| wr_data | input | 32 | Write-back word |
| copy_mismatch | output | 1 | High when both ports address one register and the copies disagree |

## Verification
On a healthy design the two copies can never diverge through the ports. The divergence flag therefore cannot be raised on purpose. Likewise, the fact that each port uses its own copy cannot be observed directly.

The stimulus instead places both ports on the same index after every kind of write. This includes a data background written with the two alternating patterns, then with the inverse patterns, across both halves of the register file. Any copy that misses a write, decodes the wrong entry, or feeds the wrong port then appears as a difference between the two operands, or as a raised flag. Read-during-write is reached by holding the write strobe and the read index on the same register across one edge, and sampling on both sides of that edge.

// File: rtl/rf_dup_pkg.sv
package rf_dup_pkg;
  localparam int unsigned RF_DATA_W = 32;
  localparam int unsigned RF_NREGS  = 32;
  localparam int unsigned RF_NCOPY  = 2;
endpackage

// File: rtl/rf_wsel.sv
module rf_wsel #(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] idx,
  output logic [NREGS-1:0]  sel
);
  // Entry 0 never selected: it is the constant-zero register.
  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    if (i == 0) begin : g_zero
      assign sel[i] = 1'b0;
    end else begin : g_dec
      assign sel[i] = we && (idx == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32,
  parameter int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [NREGS-1:0]             sel;
  logic [NREGS-1:0][DATA_W-1:0] ent;

  rf_wsel #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_wsel (
    .we  (we),
    .idx (widx),
    .sel (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= '0;
    end else begin
      for (int i = 0; i < int'(NREGS); i++) begin
        if (sel[i]) ent[i] <= wdata;
      end
    end
  end

  // Combinational read; the word stored before the edge is seen during a write.
  assign rdata = (ridx == '0) ? '0 : ent[ridx];
endmodule

// File: rtl/rf_cmp.sv
module rf_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] idx_a,
  input  logic [ADDR_W-1:0] idx_b,
  input  logic [DATA_W-1:0] dat_a,
  input  logic [DATA_W-1:0] dat_b,
  output logic              diff
);
  assign diff = (idx_a == idx_b) && (dat_a != dat_b);
endmodule

// File: rtl/rf_dup.sv
module rf_dup
  import rf_dup_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned NREGS  = RF_NREGS,
  parameter int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              copy_mismatch
);
  logic [RF_NCOPY-1:0][ADDR_W-1:0] cp_ridx;
  logic [RF_NCOPY-1:0][DATA_W-1:0] cp_rdata;

  assign cp_ridx[0] = rd_a_idx;
  assign cp_ridx[1] = rd_b_idx;

  // One full, independent bank per copy; each owns its own decoder.
  for (genvar c = 0; c < RF_NCOPY; c++) begin : g_copy
    rf_bank #(.DATA_W(DATA_W), .NREGS(NREGS), .ADDR_W(ADDR_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .widx  (wr_idx),
      .wdata (wr_data),
      .ridx  (cp_ridx[c]),
      .rdata (cp_rdata[c])
    );
  end

  assign rd_a_data = cp_rdata[0];
  assign rd_b_data = cp_rdata[1];

  rf_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
    .idx_a (rd_a_idx),
    .idx_b (rd_b_idx),
    .dat_a (rd_a_data),
    .dat_b (rd_b_data),
    .diff  (copy_mismatch)
  );
endmodule

// File: rtl/rf_dup_chk.sv
module rf_dup_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              copy_mismatch
);
  assert_zero_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));
  assert_zero_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0));
  assert_ports_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
  assert_no_divergence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_mismatch);
  assert_write_lands_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));
  assert_write_lands_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> (rd_b_idx != $past(wr_idx) || rd_b_data == $past(wr_data)));
  assert_hold_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(rd_a_idx)) |-> $stable(rd_a_data));
endmodule

bind rf_dup rf_dup_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_a_idx      (rd_a_idx),
  .rd_a_data     (rd_a_data),
  .rd_b_idx      (rd_b_idx),
  .rd_b_data     (rd_b_data),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_data       (wr_data),
  .copy_mismatch (copy_mismatch)
);

// File: tb/rf_dup_tb.sv
module rf_dup_tb;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0;
  logic          copy_mismatch;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NR];

  always #5 clk = ~clk;

  rf_dup u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .copy_mismatch(copy_mismatch)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [AW-1:0] idx, input logic [DW-1:0] d, input logic en);
    @(negedge clk);
    wr_en = en; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en && idx != 0) model[idx] = d;
  endtask

  // Reads index i on both ports and checks both words and the flag.
  task automatic rd_both(input string req, input int i);
    rd_a_idx = AW'(i); rd_b_idx = AW'(i);
    #1;
    chk({req, " port A"}, rd_a_data, model[i]);
    chk({req, " port B"}, rd_b_data, model[i]);
    chk({req, " R7 flag"}, {31'b0, copy_mismatch}, 32'h0);
  endtask

  task automatic t_reset_R1();
    for (int i = 0; i < NR; i++) model[i] = '0;
    rd_a_idx = 5'd9; rd_b_idx = 5'd9; #1;
    chk("R1 in reset A", rd_a_data, '0);
    chk("R1 in reset B", rd_b_data, '0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NR; i += 7) rd_both("R1", i);
  endtask

  task automatic t_write_R2();
    wr(5'd3, 32'hDEADBEEF, 1'b1);
    rd_both("R2", 3);
    wr(5'd31, 32'h12345678, 1'b1);
    rd_both("R2 top", 31);
  endtask

  task automatic t_ports_R3_R4();
    rd_a_idx = 5'd3; rd_b_idx = 5'd31; #1;
    chk("R3 A idx3", rd_a_data, 32'hDEADBEEF);
    chk("R4 B idx31", rd_b_data, 32'h12345678);
    chk("R7 diff idx flag low", {31'b0, copy_mismatch}, 32'h0);
    rd_a_idx = 5'd31; rd_b_idx = 5'd3; #1;
    chk("R3 A idx31", rd_a_data, 32'h12345678);
    chk("R4 B idx3", rd_b_data, 32'hDEADBEEF);
  endtask

  task automatic t_r0_R5();
    wr(5'd0, 32'hFFFFFFFF, 1'b1);
    rd_both("R5", 0);
  endtask

  task automatic t_rdw_R6();
    @(negedge clk);
    rd_a_idx = 5'd3; rd_b_idx = 5'd3;
    wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'hCAFEF00D;
    #1;
    chk("R6 old A", rd_a_data, 32'hDEADBEEF);
    chk("R6 old B", rd_b_data, 32'hDEADBEEF);
    @(posedge clk); #1;
    chk("R6 new A", rd_a_data, 32'hCAFEF00D);
    chk("R6 new B", rd_b_data, 32'hCAFEF00D);
    @(negedge clk); wr_en = 1'b0;
    model[3] = 32'hCAFEF00D;
  endtask

  task automatic t_noen_R8();
    wr(5'd3, 32'h0BADF00D, 1'b0);
    wr(5'd7, 32'h0BADF00D, 1'b0);
    rd_both("R8", 3);
    rd_both("R8", 7);
  endtask

  task automatic t_pattern_R9();
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 1; i < NR; i++) begin
        logic [DW-1:0] p;
        p = ((i % 2) == pass) ? 32'h55555555 : 32'hAAAAAAAA;
        wr(AW'(i), p, 1'b1);
      end
      for (int i = 0; i < NR; i++) rd_both("R9", i);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    t_reset_R1();
    t_write_R2();
    t_ports_R3_R4();
    t_r0_R5();
    t_rdw_R6();
    t_noen_R8();
    t_pattern_R9();
    done();
  end
endmodule